// File: doc/BRIEF.md
# Function Execution Profiler

This block watches a stream of 32-bit marker words, each stamped with a time value by an upstream capture stage. It sorts each word into one of three kinds: a function-start marker, a function-end marker, or a word that is not a marker. The low half of a marker word names the function. Start markers go onto a small stack. An end marker closes the innermost open call when the two names agree. The elapsed time between the two markers is then added to the statistics kept for that function.

Statistics live in a fixed table of slots. A function gets a slot the first time its name appears in any marker. Each slot holds the shortest call, the longest call, a running total of call time and a call count. A host reads these and divides the total by the count to get the average. A slot that is in use also serves as coverage evidence, because it shows the function was reached at least once.

Three sticky flags report trouble: an end marker that does not close the innermost open call, a start marker arriving when the stack is full, and a new name arriving when the table is full. A synchronous clear input returns the whole block to its empty state in a single cycle.

Top module: `fn_profiler`

## Requirements
- R1: A valid word whose bits 31:16 equal 16'hAAAA is a start marker, and a valid word whose bits 31:16 equal 16'h5555 is an end marker. In both cases bits 15:0 carry the function name.
- R2: A valid word whose bits 31:16 hold any other value changes neither the stack, the table nor the flags.
- R3: When an end marker closes a call, its duration is the end stamp minus the start stamp, taken modulo 2^TS_W. That duration updates the named slot's minimum, maximum, total and count, and the new values can be read in the cycle after the end marker.
- R4: A slot that has never been updated reads a minimum of all ones, a maximum of zero, a total of zero and a count of zero. An unallocated slot also reads `rd_used` = 0.
- R5: Slots are handed out in ascending index order, starting at slot 0, in the order names first appear in start or end markers. `rd_used` = 1 marks a name that has been seen.
- R6: An end marker that arrives with an empty stack, or whose name differs from the innermost open call, sets `err_mismatch`. It leaves the stack and the statistics unchanged.
- R7: Nested calls pair each end marker with the innermost open start marker. An outer call's duration therefore includes the time spent in its inner calls.
- R8: A start marker that arrives when STACK_DEPTH calls are already open is dropped and sets `err_nest`.
- R9: A name first seen when all SLOTS slots are in use gets no slot, sets `err_table`, and never has statistics recorded.
- R10: The total saturates at all ones and the count saturates at all ones; neither wraps.
- R11: `clr` empties the stack, frees every slot and lowers all flags in one cycle. It takes priority over a marker in the same cycle.
- R12: After `rst` every slot is free, the stack is empty and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of stack, table and flags |
| tag_vld | input | 1 | Marker word valid this cycle |
| tag_word | input | 32 | Marker word: kind code in 31:16, function name in 15:0 |
| tag_ts | input | TS_W | Time stamp of the marker word |
| rd_slot | input | $clog2(SLOTS) | Slot selected on the read port |
| rd_used | output | 1 | Selected slot holds a name |
| rd_id | output | 16 | Function name held by the slot |
| rd_min | output | TS_W | Shortest call duration |
| rd_max | output | TS_W | Longest call duration |
| rd_sum | output | SUM_W | Saturating total of call durations |
| rd_cnt | output | CNT_W | Saturating call count |
| err_mismatch | output | 1 | Sticky: unmatched end marker seen |
| err_nest | output | 1 | Sticky: start marker dropped on a full stack |
| err_table | output | 1 | Sticky: new name found the table full |

## Verification
The first pattern is a flat series of start/end pairs. It shows that durations land in the right slot and that minimum and maximum track values which differ from call to call. A nested pattern with a non-marker word in the middle separates innermost-first pairing from simple adjacent pairing, and shows that junk words are ignored. Several further patterns probe the edges: an end marker on an empty stack, an end marker with a foreign name, stamps that wrap around, an overfilled stack, a seventeenth name, hundreds of maximum-length calls that saturate both total and count, and a clear issued together with a marker. Each of these exposes a distinct fault in the error path, the saturation logic or the clear priority.

// File: rtl/fp_pkg.sv
package fp_pkg;

    localparam int TAG_W    = 32;
    localparam int TAG_ID_W = 16;

    localparam logic [TAG_ID_W-1:0] CODE_START = 16'hAAAA;
    localparam logic [TAG_ID_W-1:0] CODE_END   = 16'h5555;

    typedef enum logic [1:0] {
        MK_NONE  = 2'd0,
        MK_START = 2'd1,
        MK_END   = 2'd2
    } mark_kind_e;

    typedef struct packed {
        mark_kind_e            kind;
        logic [TAG_ID_W-1:0]   name;
    } mark_t;

    function automatic mark_t decode_mark(input logic vld, input logic [TAG_W-1:0] w);
        mark_t m;
        m.name = w[TAG_ID_W-1:0];
        if (!vld)
            m.kind = MK_NONE;
        else if (w[TAG_W-1:TAG_ID_W] == CODE_START)
            m.kind = MK_START;
        else if (w[TAG_W-1:TAG_ID_W] == CODE_END)
            m.kind = MK_END;
        else
            m.kind = MK_NONE;
        return m;
    endfunction

endpackage

// File: rtl/fp_call_stack.sv
module fp_call_stack #(
    parameter int DEPTH = 8,
    parameter int ID_W  = 16,
    parameter int TS_W  = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            push,
    input  logic            pop,
    input  logic [ID_W-1:0] push_id,
    input  logic [TS_W-1:0] push_ts,
    output logic [ID_W-1:0] top_id,
    output logic [TS_W-1:0] top_ts,
    output logic            empty,
    output logic            full,
    output logic [$clog2(DEPTH+1)-1:0] depth
);
    localparam int DW = $clog2(DEPTH+1);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [ID_W-1:0] id_mem [DEPTH];
    logic [TS_W-1:0] ts_mem [DEPTH];
    logic [DW-1:0]   level;
    logic [DW-1:0]   top_lvl;

    assign depth   = level;
    assign empty   = (level == '0);
    assign full    = (level == DW'(DEPTH));
    assign top_lvl = level - 1'b1;

    always_comb begin
        if (empty) begin
            top_id = '0;
            top_ts = '0;
        end else begin
            top_id = id_mem[top_lvl[PW-1:0]];
            top_ts = ts_mem[top_lvl[PW-1:0]];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            level <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                id_mem[i] <= '0;
                ts_mem[i] <= '0;
            end
        end else if (push && !full) begin
            id_mem[level[PW-1:0]] <= push_id;
            ts_mem[level[PW-1:0]] <= push_ts;
            level <= level + 1'b1;
        end else if (pop && !empty) begin
            level <= level - 1'b1;
        end
    end

endmodule

// File: rtl/fp_stat_table.sv
module fp_stat_table #(
    parameter int SLOTS = 16,
    parameter int ID_W  = 16,
    parameter int TS_W  = 32,
    parameter int SUM_W = 48,
    parameter int CNT_W = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clr,
    input  logic                          seen_vld,
    input  logic [ID_W-1:0]               seen_id,
    input  logic                          upd_vld,
    input  logic [ID_W-1:0]               upd_id,
    input  logic [TS_W-1:0]               upd_dur,
    input  logic [$clog2(SLOTS)-1:0]      rd_slot,
    output logic                          rd_used,
    output logic [ID_W-1:0]               rd_id,
    output logic [TS_W-1:0]               rd_min,
    output logic [TS_W-1:0]               rd_max,
    output logic [SUM_W-1:0]              rd_sum,
    output logic [CNT_W-1:0]              rd_cnt,
    output logic                          no_room,
    output logic [$clog2(SLOTS+1)-1:0]    n_used
);
    localparam int SLW = $clog2(SLOTS);
    localparam int CW  = $clog2(SLOTS+1);

    logic [SLOTS-1:0] used_q;
    logic [ID_W-1:0]  id_q  [SLOTS];
    logic [TS_W-1:0]  min_q [SLOTS];
    logic [TS_W-1:0]  max_q [SLOTS];
    logic [SUM_W-1:0] sum_q [SLOTS];
    logic [CNT_W-1:0] cnt_q [SLOTS];
    logic [CW-1:0]    fill_q;

    logic [SLOTS-1:0] seen_hit;
    logic [SLOTS-1:0] upd_hit;
    logic             tbl_full;
    logic             alloc;

    for (genvar g = 0; g < SLOTS; g++) begin : g_match
        assign seen_hit[g] = used_q[g] && (id_q[g] == seen_id);
        assign upd_hit[g]  = used_q[g] && (id_q[g] == upd_id);
    end

    assign tbl_full = (fill_q == CW'(SLOTS));
    assign alloc    = seen_vld && !(|seen_hit) && !tbl_full;
    assign no_room  = seen_vld && !(|seen_hit) && tbl_full;
    assign n_used   = fill_q;

    function automatic logic [SUM_W-1:0] add_sat(input logic [SUM_W-1:0] a,
                                                 input logic [TS_W-1:0]  d);
        logic [SUM_W:0] t;
        t = {1'b0, a} + (SUM_W+1)'(d);
        return t[SUM_W] ? '1 : t[SUM_W-1:0];
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            used_q <= '0;
            fill_q <= '0;
            for (int i = 0; i < SLOTS; i++) begin
                id_q[i]  <= '0;
                min_q[i] <= '1;
                max_q[i] <= '0;
                sum_q[i] <= '0;
                cnt_q[i] <= '0;
            end
        end else begin
            if (alloc) begin
                used_q[fill_q[SLW-1:0]] <= 1'b1;
                id_q[fill_q[SLW-1:0]]   <= seen_id;
                fill_q                  <= fill_q + 1'b1;
            end
            for (int i = 0; i < SLOTS; i++) begin
                if (upd_vld && upd_hit[i]) begin
                    if (upd_dur < min_q[i]) min_q[i] <= upd_dur;
                    if (upd_dur > max_q[i]) max_q[i] <= upd_dur;
                    sum_q[i] <= add_sat(sum_q[i], upd_dur);
                    if (cnt_q[i] != '1) cnt_q[i] <= cnt_q[i] + 1'b1;
                end
            end
        end
    end

    assign rd_used = used_q[rd_slot];
    assign rd_id   = id_q[rd_slot];
    assign rd_min  = min_q[rd_slot];
    assign rd_max  = max_q[rd_slot];
    assign rd_sum  = sum_q[rd_slot];
    assign rd_cnt  = cnt_q[rd_slot];

endmodule

// File: rtl/fn_profiler.sv
module fn_profiler
    import fp_pkg::*;
#(
    parameter int TS_W        = 32,
    parameter int SLOTS       = 16,
    parameter int STACK_DEPTH = 8,
    parameter int SUM_W       = 48,
    parameter int CNT_W       = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     tag_vld,
    input  logic [31:0]              tag_word,
    input  logic [TS_W-1:0]          tag_ts,
    input  logic [$clog2(SLOTS)-1:0] rd_slot,
    output logic                     rd_used,
    output logic [15:0]              rd_id,
    output logic [TS_W-1:0]          rd_min,
    output logic [TS_W-1:0]          rd_max,
    output logic [SUM_W-1:0]         rd_sum,
    output logic [CNT_W-1:0]         rd_cnt,
    output logic                     err_mismatch,
    output logic                     err_nest,
    output logic                     err_table
);
    localparam int DW = $clog2(STACK_DEPTH+1);
    localparam int CW = $clog2(SLOTS+1);

    mark_t                mk;
    logic                 is_start;
    logic                 is_end;
    logic                 stk_empty;
    logic                 stk_full;
    logic [DW-1:0]        stk_depth;
    logic [TAG_ID_W-1:0]  open_id;
    logic [TS_W-1:0]      open_ts;
    logic                 exit_match;
    logic                 exit_bad;
    logic                 nest_drop;
    logic                 tbl_drop;
    logic [TS_W-1:0]      call_dur;
    logic [CW-1:0]        n_used;

    assign mk         = decode_mark(tag_vld, tag_word);
    assign is_start   = (mk.kind == MK_START);
    assign is_end     = (mk.kind == MK_END);
    assign exit_match = is_end && !stk_empty && (open_id == mk.name);
    assign exit_bad   = is_end && !exit_match;
    assign nest_drop  = is_start && stk_full;
    assign call_dur   = tag_ts - open_ts;

    fp_call_stack #(
        .DEPTH (STACK_DEPTH),
        .ID_W  (TAG_ID_W),
        .TS_W  (TS_W)
    ) u_stack (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .push    (is_start),
        .pop     (exit_match),
        .push_id (mk.name),
        .push_ts (tag_ts),
        .top_id  (open_id),
        .top_ts  (open_ts),
        .empty   (stk_empty),
        .full    (stk_full),
        .depth   (stk_depth)
    );

    fp_stat_table #(
        .SLOTS (SLOTS),
        .ID_W  (TAG_ID_W),
        .TS_W  (TS_W),
        .SUM_W (SUM_W),
        .CNT_W (CNT_W)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .seen_vld (is_start || is_end),
        .seen_id  (mk.name),
        .upd_vld  (exit_match),
        .upd_id   (mk.name),
        .upd_dur  (call_dur),
        .rd_slot  (rd_slot),
        .rd_used  (rd_used),
        .rd_id    (rd_id),
        .rd_min   (rd_min),
        .rd_max   (rd_max),
        .rd_sum   (rd_sum),
        .rd_cnt   (rd_cnt),
        .no_room  (tbl_drop),
        .n_used   (n_used)
    );

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            err_mismatch <= 1'b0;
            err_nest     <= 1'b0;
            err_table    <= 1'b0;
        end else begin
            if (exit_bad)  err_mismatch <= 1'b1;
            if (nest_drop) err_nest     <= 1'b1;
            if (tbl_drop)  err_table    <= 1'b1;
        end
    end

endmodule

// File: rtl/fn_profiler_chk.sv
module fn_profiler_chk #(
    parameter int SLOTS       = 16,
    parameter int STACK_DEPTH = 8
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           clr,
    input logic [$clog2(STACK_DEPTH+1)-1:0] depth,
    input logic [$clog2(SLOTS+1)-1:0]     n_used,
    input logic                           exit_match,
    input logic                           err_mismatch,
    input logic                           err_nest,
    input logic                           err_table
);
    // R11: one-cycle clear of everything
    p_clear_empties_r11: assert property (@(posedge clk) disable iff (rst)
        clr |=> (depth == '0 && n_used == '0 && !err_mismatch && !err_nest && !err_table));

    // R6: mismatch flag holds until cleared
    p_mismatch_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (err_mismatch && !clr) |=> err_mismatch);

    // R9: table overflow only rises with every slot taken
    p_table_ovf_full_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(err_table) |-> ($past(n_used) == SLOTS));

    // R8: stack never exceeds its depth
    p_depth_bound_r8: assert property (@(posedge clk) disable iff (rst)
        depth <= STACK_DEPTH);

    // R7: a closed call pops exactly one level
    p_pop_one_r7: assert property (@(posedge clk) disable iff (rst)
        (exit_match && !clr) |=> (depth == $past(depth) - 1'b1));

    // R5: slots fill one at a time
    p_alloc_step_r5: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((n_used == $past(n_used)) || (n_used == $past(n_used) + 1'b1)));

endmodule

bind fn_profiler fn_profiler_chk #(
    .SLOTS       (SLOTS),
    .STACK_DEPTH (STACK_DEPTH)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .clr          (clr),
    .depth        (stk_depth),
    .n_used       (n_used),
    .exit_match   (exit_match),
    .err_mismatch (err_mismatch),
    .err_nest     (err_nest),
    .err_table    (err_table)
);

// File: tb/fn_profiler_bench.sv
`timescale 1ns/1ps
module fn_profiler_bench;
    localparam int TS_W  = 32;
    localparam int SLOTS = 16;
    localparam int DEPTH = 8;
    localparam int SUM_W = 36;
    localparam int CNT_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              clr = 1'b0;
    logic              tag_vld = 1'b0;
    logic [31:0]       tag_word = '0;
    logic [TS_W-1:0]   tag_ts = '0;
    logic [3:0]        rd_slot = '0;
    logic              rd_used;
    logic [15:0]       rd_id;
    logic [TS_W-1:0]   rd_min, rd_max;
    logic [SUM_W-1:0]  rd_sum;
    logic [CNT_W-1:0]  rd_cnt;
    logic              err_mismatch, err_nest, err_table;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    fn_profiler #(
        .TS_W(TS_W), .SLOTS(SLOTS), .STACK_DEPTH(DEPTH), .SUM_W(SUM_W), .CNT_W(CNT_W)
    ) u_fn_profiler (
        .clk(clk), .rst(rst), .clr(clr), .tag_vld(tag_vld), .tag_word(tag_word),
        .tag_ts(tag_ts), .rd_slot(rd_slot), .rd_used(rd_used), .rd_id(rd_id),
        .rd_min(rd_min), .rd_max(rd_max), .rd_sum(rd_sum), .rd_cnt(rd_cnt),
        .err_mismatch(err_mismatch), .err_nest(err_nest), .err_table(err_table)
    );

    // {marker word, time stamp, expected mismatch flag afterwards}
    localparam logic [64:0] VEC [12] = '{
        {32'hAAAA03E7, 32'd100, 1'b0},
        {32'h555503E7, 32'd150, 1'b0},
        {32'hAAAA045A, 32'd200, 1'b0},
        {32'h5555045A, 32'd210, 1'b0},
        {32'hAAAAC40F, 32'd300, 1'b0},
        {32'hAAAA045A, 32'd305, 1'b0},
        {32'h5555045A, 32'd405, 1'b0},
        {32'h1234ABCD, 32'd410, 1'b0},
        {32'h5555C40F, 32'd500, 1'b0},
        {32'h555500A4, 32'd510, 1'b1},
        {32'hAAAA03E7, 32'd600, 1'b1},
        {32'h555503E7, 32'd601, 1'b1}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] w, input logic [TS_W-1:0] t);
        @(negedge clk);
        tag_vld  = 1'b1;
        tag_word = w;
        tag_ts   = t;
        @(negedge clk);
        tag_vld  = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic sel(input int s);
        rd_slot = 4'(s);
        #1;
    endtask

    task automatic chk_slot(input string req, input int s, input logic u, input logic [15:0] id,
                            input logic [63:0] mn, input logic [63:0] mx,
                            input logic [63:0] sm, input logic [63:0] cn);
        sel(s);
        chk({req, " used"}, 64'(rd_used), 64'(u));
        if (u) chk({req, " id"}, 64'(rd_id), 64'(id));
        chk({req, " min"}, 64'(rd_min), mn);
        chk({req, " max"}, 64'(rd_max), mx);
        chk({req, " sum"}, 64'(rd_sum), sm);
        chk({req, " cnt"}, 64'(rd_cnt), cn);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 / R4: reset state
        chk("R12 flags", {61'd0, err_mismatch, err_nest, err_table}, 64'd0);
        chk_slot("R4 R12 slot0", 0, 1'b0, 16'h0, 64'hFFFFFFFF, 64'd0, 64'd0, 64'd0);

        // R1 R3 R6 R7 R2: vector walk
        for (int i = 0; i < 12; i++) begin
            send(VEC[i][64:33], VEC[i][32:1]);
            chk($sformatf("R6 step%0d mismatch", i), 64'(err_mismatch), 64'(VEC[i][0]));
        end
        chk_slot("R3 slot0", 0, 1'b1, 16'h03E7, 64'd1, 64'd50, 64'd51, 64'd2);
        chk_slot("R7 slot1", 1, 1'b1, 16'h045A, 64'd10, 64'd100, 64'd110, 64'd2);
        chk_slot("R7 slot2", 2, 1'b1, 16'hC40F, 64'd200, 64'd200, 64'd200, 64'd1);
        chk_slot("R5 slot3", 3, 1'b1, 16'h00A4, 64'hFFFFFFFF, 64'd0, 64'd0, 64'd0);
        chk_slot("R2 slot4", 4, 1'b0, 16'h0, 64'hFFFFFFFF, 64'd0, 64'd0, 64'd0);

        // R11: clear
        do_clear();
        chk("R11 flags", {61'd0, err_mismatch, err_nest, err_table}, 64'd0);
        chk_slot("R11 slot0", 0, 1'b0, 16'h0, 64'hFFFFFFFF, 64'd0, 64'd0, 64'd0);

        // R6: foreign name leaves stack intact
        send(32'hAAAA0001, 32'd0);
        send(32'h55550002, 32'd5);
        chk("R6 foreign", 64'(err_mismatch), 64'd1);
        send(32'h55550001, 32'd9);
        chk_slot("R6 kept", 0, 1'b1, 16'h0001, 64'd9, 64'd9, 64'd9, 64'd1);
        chk_slot("R6 no stats", 1, 1'b1, 16'h0002, 64'hFFFFFFFF, 64'd0, 64'd0, 64'd0);

        // R3: stamp wrap
        do_clear();
        send(32'hAAAA0042, 32'hFFFFFFF0);
        send(32'h55550042, 32'h00000010);
        chk_slot("R3 wrap", 0, 1'b1, 16'h0042, 64'h20, 64'h20, 64'h20, 64'd1);

        // R8: stack overflow
        do_clear();
        for (int i = 0; i < 9; i++) begin
            send(32'hAAAA0007, TS_W'(i));
            if (i == 7) chk("R8 not yet", 64'(err_nest), 64'd0);
        end
        chk("R8 nest flag", 64'(err_nest), 64'd1);
        for (int i = 0; i < 8; i++) send(32'h55550007, TS_W'(100 + i));
        chk("R8 no mismatch", 64'(err_mismatch), 64'd0);
        chk_slot("R8 slot0", 0, 1'b1, 16'h0007, 64'd93, 64'd107, 64'd800, 64'd8);
        send(32'h55550007, 32'd200);
        chk("R8 extra dropped", 64'(err_mismatch), 64'd1);

        // R9: table overflow
        do_clear();
        for (int i = 0; i < 16; i++) begin
            send({16'hAAAA, 16'(16'h10 + i)}, 32'd0);
            send({16'h5555, 16'(16'h10 + i)}, 32'd3);
        end
        chk("R9 not yet", 64'(err_table), 64'd0);
        chk_slot("R5 slot15", 15, 1'b1, 16'h001F, 64'd3, 64'd3, 64'd3, 64'd1);
        send(32'hAAAA0020, 32'd0);
        send(32'h55550020, 32'd4);
        chk("R9 table flag", 64'(err_table), 64'd1);
        chk("R9 no mismatch", 64'(err_mismatch), 64'd0);
        chk_slot("R9 slot0 intact", 0, 1'b1, 16'h0010, 64'd3, 64'd3, 64'd3, 64'd1);

        // R10: saturation
        do_clear();
        for (int i = 0; i < 300; i++) begin
            send(32'hAAAA0005, 32'h00000000);
            send(32'h55550005, 32'hFFFFFFFF);
        end
        chk_slot("R10 sat", 0, 1'b1, 16'h0005, 64'hFFFFFFFF, 64'hFFFFFFFF,
                 64'hF_FFFF_FFFF, 64'hFF);

        // R11: clear wins over marker in same cycle
        @(negedge clk);
        clr = 1'b1; tag_vld = 1'b1; tag_word = 32'hAAAA0001; tag_ts = 32'd0;
        @(negedge clk);
        clr = 1'b0; tag_vld = 1'b0;
        chk_slot("R11 priority", 0, 1'b0, 16'h0, 64'hFFFFFFFF, 64'd0, 64'd0, 64'd0);
        send(32'h55550001, 32'd5);
        chk("R11 stack empty", 64'(err_mismatch), 64'd1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule